// File: doc/BRIEF.md
# Mode-Gated Multiplexed GPIO Controller

This block turns up to 64 shared address, data and auxiliary bus pads into general-purpose I/O. A two-bit chip configuration, captured once after reset, decides which pads are handed to GPIO. The rest stay under the control of the external bus logic, and the block passes the bus output value and output-enable through to them unchanged. For every pad the block drives an output value, an output-enable and a GPIO-select flag. It also samples the pad input through a two-flop synchroniser.

Software reaches the block through a small word-wide register port with a single-cycle write strobe and a combinational read. There are registers for output data (low and high word), read-only input data (low and high word), six group direction bits and sixteen per-pin direction bits. Forty-eight pads take their direction from a bit shared by a byte group. The other sixteen pads each have their own direction bit. A direction bit of 1 makes the pad an output.

Top module: `mgpio_top`

## Requirements
- R1: Pad numbering: pads 0..31 are data bus bits 0..31, pads 32..55 are address bus bits 8..31, and pads 56..63 form the auxiliary set.
- R2: `mode_cfg_i` is captured on the first rising clock edge after reset release and then held until the next reset, whatever the input does. Until it is captured, pads are granted as in mode 00.
- R3: Grant per mode, where `gpio_sel_o` bit = 1 means the pad is GPIO. 00 grants pads 56..63. 01 grants pads 16..31 and 56..63. 10 grants pads 0..31 and 56..63. 11 grants all 64 pads.
- R4: The group direction register (address 4, bits 5:0) works as follows. Bits 0, 1 and 2 control pads 0..7, 8..15 and 16..23. Bits 3, 4 and 5 control pads 32..39, 40..47 and 48..55. A read returns the six bits zero-extended.
- R5: The per-pin direction register (address 5, bits 15:0) works as follows. Bit i (i<8) controls pad 24+i. Bit 8+i controls pad 56+i. A read returns the bits zero-extended.
- R6: On a granted pad, `pad_oe_o` equals its direction bit and `pad_o_o` equals its output-data bit.
- R7: On a non-granted pad, `pad_o_o` and `pad_oe_o` equal `bus_o_i` and `bus_oe_i`. Writes to that pad's data or direction bits are still stored and read back, but they do not change the pad.
- R8: Address 2 reads pads 31..0 and address 3 reads pads 63..32. For every pad, the value read is the pad input as sampled two clock edges earlier.
- R9: Reset clears output data and all direction bits, so no granted pad drives.
- R10: Register map: 0 and 1 are the read/write output-data words for pads 31..0 and 63..32. Writes to 2 and 3 are ignored. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_cfg_i | input | 2 | Chip configuration, captured after reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| bus_o_i | input | 64 | Bus output value for each pad |
| bus_oe_i | input | 64 | Bus output-enable for each pad |
| pad_i | input | 64 | Pad input values |
| pad_o_o | output | 64 | Pad output values |
| pad_oe_o | output | 64 | Pad output-enables |
| gpio_sel_o | output | 64 | 1 = pad is in GPIO mode |

## Verification
The properties assume that `mode_cfg_i` matters only at the first edge after reset and that register writes are single-cycle strobes with a stable address. The bench applies every mode through a full reset. It then deliberately moves `mode_cfg_i` after capture, to show that the input is ignored from then on. Between directed corner cases, random writes and random bus inputs change only at the falling edge. Pad inputs are held for at least two edges before their synchronised value is read back.

// File: rtl/mgpio_pkg.sv
`timescale 1ns/1ps
package mgpio_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_PADS  = 24;
  localparam int AUX_W      = 8;
  localparam int NUM_PADS   = DATA_W + ADDR_PADS + AUX_W;
  localparam int GROUP_W    = 8;
  localparam int DATA_GRPS  = (DATA_W - GROUP_W) / GROUP_W;
  localparam int NUM_GROUPS = DATA_GRPS + ADDR_PADS / GROUP_W;
  localparam int NUM_SINGLE = GROUP_W + AUX_W;
  localparam int REG_W      = 32;
  localparam int RADDR_W    = 3;

  typedef enum logic [1:0] {
    MODE_PORT32 = 2'b00,
    MODE_PORT16 = 2'b01,
    MODE_TRACE  = 2'b10,
    MODE_SINGLE = 2'b11
  } chip_mode_e;

  typedef enum logic [RADDR_W-1:0] {
    RA_DOUT_LO = 3'd0,
    RA_DOUT_HI = 3'd1,
    RA_DIN_LO  = 3'd2,
    RA_DIN_HI  = 3'd3,
    RA_GDIR    = 3'd4,
    RA_PDIR    = 3'd5
  } reg_addr_e;

  function automatic int grp_base(int g);
    return (g < DATA_GRPS) ? g * GROUP_W : DATA_W + (g - DATA_GRPS) * GROUP_W;
  endfunction

  function automatic int single_pad(int s);
    return (s < GROUP_W) ? DATA_GRPS * GROUP_W + s : DATA_W + ADDR_PADS + (s - GROUP_W);
  endfunction
endpackage

// File: rtl/mgpio_dir_expand.sv
`timescale 1ns/1ps
module mgpio_dir_expand
  import mgpio_pkg::*;
(
  input  logic [NUM_GROUPS-1:0] grp_dir_i,
  input  logic [NUM_SINGLE-1:0] pin_dir_i,
  output logic [NUM_PADS-1:0]   dir_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign dir_o[grp_base(g) +: GROUP_W] = {GROUP_W{grp_dir_i[g]}};
  end
  for (genvar s = 0; s < NUM_SINGLE; s++) begin : g_pin
    assign dir_o[single_pad(s)] = pin_dir_i[s];
  end
endmodule

// File: rtl/mgpio_grant.sv
`timescale 1ns/1ps
module mgpio_grant
  import mgpio_pkg::*;
(
  input  chip_mode_e          mode_i,
  output logic [NUM_PADS-1:0] grant_o
);
  localparam logic [NUM_PADS-1:0] AUX_M  = {{AUX_W{1'b1}}, {(NUM_PADS-AUX_W){1'b0}}};
  localparam logic [NUM_PADS-1:0] DATA_M = {{(NUM_PADS-DATA_W){1'b0}}, {DATA_W{1'b1}}};
  localparam logic [NUM_PADS-1:0] HALF_M = {{(NUM_PADS-DATA_W){1'b0}}, {(DATA_W/2){1'b1}},
                                            {(DATA_W/2){1'b0}}};

  always_comb begin
    unique case (mode_i)
      MODE_PORT32: grant_o = AUX_M;
      MODE_PORT16: grant_o = AUX_M | HALF_M;
      MODE_TRACE:  grant_o = AUX_M | DATA_M;
      default:     grant_o = '1;
    endcase
  end
endmodule

// File: rtl/mgpio_sync.sv
`timescale 1ns/1ps
module mgpio_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mgpio_regs.sv
`timescale 1ns/1ps
module mgpio_regs
  import mgpio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [RADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  input  logic [NUM_PADS-1:0]   din_i,
  output logic [NUM_PADS-1:0]   dout_o,
  output logic [NUM_GROUPS-1:0] grp_dir_o,
  output logic [NUM_SINGLE-1:0] pin_dir_o
);
  logic [NUM_PADS-1:0]   dout_q;
  logic [NUM_GROUPS-1:0] gdir_q;
  logic [NUM_SINGLE-1:0] pdir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      gdir_q <= '0;
      pdir_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_DOUT_LO: dout_q[REG_W-1:0]        <= wdata_i;
        RA_DOUT_HI: dout_q[NUM_PADS-1:REG_W] <= wdata_i;
        RA_GDIR:    gdir_q <= wdata_i[NUM_GROUPS-1:0];
        RA_PDIR:    pdir_q <= wdata_i[NUM_SINGLE-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RA_DOUT_LO: rdata_o = dout_q[REG_W-1:0];
      RA_DOUT_HI: rdata_o = dout_q[NUM_PADS-1:REG_W];
      RA_DIN_LO:  rdata_o = din_i[REG_W-1:0];
      RA_DIN_HI:  rdata_o = din_i[NUM_PADS-1:REG_W];
      RA_GDIR:    rdata_o = REG_W'(gdir_q);
      RA_PDIR:    rdata_o = REG_W'(pdir_q);
      default:    rdata_o = '0;
    endcase
  end

  assign dout_o    = dout_q;
  assign grp_dir_o = gdir_q;
  assign pin_dir_o = pdir_q;
endmodule

// File: rtl/mgpio_top.sv
`timescale 1ns/1ps
module mgpio_top
  import mgpio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_cfg_i,
  input  logic                wr_en_i,
  input  logic [RADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PADS-1:0] bus_o_i,
  input  logic [NUM_PADS-1:0] bus_oe_i,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] pad_o_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic [NUM_PADS-1:0] gpio_sel_o
);
  chip_mode_e            mode_q;
  logic                  cfg_done_q;
  logic [NUM_PADS-1:0]   din, dout, dir, grant;
  logic [NUM_GROUPS-1:0] gdir;
  logic [NUM_SINGLE-1:0] pdir;

  // configuration is latched once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_PORT32;
      cfg_done_q <= 1'b0;
    end else if (!cfg_done_q) begin
      mode_q     <= chip_mode_e'(mode_cfg_i);
      cfg_done_q <= 1'b1;
    end
  end

  mgpio_sync #(.W(NUM_PADS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(din)
  );

  mgpio_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .din_i    (din),
    .dout_o   (dout),
    .grp_dir_o(gdir),
    .pin_dir_o(pdir)
  );

  mgpio_dir_expand u_dir (.grp_dir_i(gdir), .pin_dir_i(pdir), .dir_o(dir));
  mgpio_grant      u_grant (.mode_i(mode_q), .grant_o(grant));

  assign gpio_sel_o = grant;
  assign pad_o_o    = (grant & dout) | (~grant & bus_o_i);
  assign pad_oe_o   = (grant & dir)  | (~grant & bus_oe_i);
endmodule

// File: rtl/mgpio_chk.sv
`timescale 1ns/1ps
module mgpio_chk
  import mgpio_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [RADDR_W-1:0]  addr_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [REG_W-1:0]    rdata_o,
  input logic [DATA_W-1:0]   pad_lo_i,
  input logic [NUM_PADS-1:0] bus_o_i,
  input logic [NUM_PADS-1:0] bus_oe_i,
  input logic [NUM_PADS-1:0] pad_o_o,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input logic [NUM_PADS-1:0] gpio_sel_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_aux_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &gpio_sel_o[NUM_PADS-1:NUM_PADS-AUX_W]);

  p_nested_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_sel_o[0] |-> (&gpio_sel_o[DATA_W-1:0]));

  p_addr_needs_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_sel_o[DATA_W] |-> gpio_sel_o[0]);

  p_sel_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> $stable(gpio_sel_o));

  p_reset_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0) |-> ((pad_oe_o & gpio_sel_o) == '0));

  p_dout_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_DOUT_LO) |=>
      (((pad_o_o[DATA_W-1:0] ^ $past(wdata_i)) & gpio_sel_o[DATA_W-1:0]
        & pad_oe_o[DATA_W-1:0]) == '0));

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((((pad_o_o ^ bus_o_i) | (pad_oe_o ^ bus_oe_i)) & ~gpio_sel_o) == '0));

  p_din_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && addr_i == RA_DIN_LO) |-> (rdata_o == $past(pad_lo_i, 2)));
endmodule

bind mgpio_top mgpio_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_lo_i  (pad_i[31:0]),
  .bus_o_i   (bus_o_i),
  .bus_oe_i  (bus_oe_i),
  .pad_o_o   (pad_o_o),
  .pad_oe_o  (pad_oe_o),
  .gpio_sel_o(gpio_sel_o)
);

// File: tb/mgpio_top_tb.sv
`timescale 1ns/1ps
module mgpio_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_cfg = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] bus_o = '0, bus_oe = '0, pad_in = '0;
  logic [63:0] pad_o, pad_oe, sel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_dout;
  logic [5:0]  m_gdir;
  logic [15:0] m_pdir;

  always #10 clk = ~clk;

  mgpio_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_cfg_i(mode_cfg), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .bus_o_i(bus_o),
    .bus_oe_i(bus_oe), .pad_i(pad_in), .pad_o_o(pad_o), .pad_oe_o(pad_oe),
    .gpio_sel_o(sel)
  );

  function automatic logic [63:0] exp_sel(input logic [1:0] m);
    case (m)
      2'b00:   return 64'hFF00_0000_0000_0000;
      2'b01:   return 64'hFF00_0000_FFFF_0000;
      2'b10:   return 64'hFF00_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [63:0] exp_dir(input logic [5:0] g, input logic [15:0] p);
    logic [63:0] d;
    for (int k = 0; k < 64; k++) begin
      if (k < 24)      d[k] = g[k/8];
      else if (k < 32) d[k] = p[k-24];
      else if (k < 56) d[k] = g[3 + (k-32)/8];
      else             d[k] = p[8 + k - 56];
    end
    return d;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_cfg = m;
    repeat (2) @(negedge clk);
    chk("R2 pre-capture grant", sel, exp_sel(2'b00));
    rst_n = 1'b1;
    @(negedge clk);
    m_dout = '0; m_gdir = '0; m_pdir = '0;
  endtask

  task automatic chk_pads(input logic [1:0] m, input string tag);
    logic [63:0] s, d;
    s = exp_sel(m);
    d = exp_dir(m_gdir, m_pdir);
    #1;
    chk({tag, " pad_o"},  pad_o,  (s & m_dout) | (~s & bus_o));
    chk({tag, " pad_oe"}, pad_oe, (s & d) | (~s & bus_oe));
  endtask

  initial begin
    logic [31:0] r;
    logic [63:0] a_val, b_val;
    void'($urandom(32'd4242));
    for (int mi = 3; mi >= 0; mi--) begin
      logic [1:0] m;
      m = 2'(mi);
      do_reset(m);
      // R9 reset state
      rd(3'd4, r); chk("R9 gdir reset", 64'(r), 64'd0);
      rd(3'd5, r); chk("R9 pdir reset", 64'(r), 64'd0);
      rd(3'd0, r); chk("R9 dout reset", 64'(r), 64'd0);
      chk("R9 no granted drive", pad_oe & sel, 64'd0);
      chk("R3 R1 grant map", sel, exp_sel(m));
      // R2 captured mode held
      mode_cfg = ~m;
      repeat (4) @(negedge clk);
      chk("R2 mode held", sel, exp_sel(m));
      // R6/R7 random mix
      for (int it = 0; it < 40; it++) begin
        logic [31:0] v;
        v = $urandom;
        case ($urandom % 5)
          0: begin wr(3'd0, v); m_dout[31:0] = v; end
          1: begin wr(3'd1, v); m_dout[63:32] = v; end
          2: begin wr(3'd4, v); m_gdir = v[5:0]; end
          3: begin wr(3'd5, v); m_pdir = v[15:0]; end
          default: begin
            @(negedge clk);
            bus_o = {$urandom, $urandom};
            bus_oe = {$urandom, $urandom};
          end
        endcase
        chk_pads(m, "R6 R7");
      end
      // R7 R10 stored values read back even on non-granted pads
      rd(3'd0, r); chk("R7 R10 dout lo readback", 64'(r), 64'(m_dout[31:0]));
      rd(3'd1, r); chk("R7 R10 dout hi readback", 64'(r), 64'(m_dout[63:32]));
      rd(3'd4, r); chk("R4 gdir readback", 64'(r), 64'(m_gdir));
      rd(3'd5, r); chk("R5 pdir readback", 64'(r), 64'(m_pdir));
      // R8 synchroniser latency
      a_val = {$urandom, $urandom};
      b_val = ~a_val;
      @(negedge clk); pad_in = a_val;
      repeat (3) @(negedge clk);
      pad_in = b_val;
      @(negedge clk);
      rd(3'd2, r); chk("R8 din one edge old", 64'(r), 64'(a_val[31:0]));
      @(negedge clk);
      rd(3'd2, r); chk("R8 din lo", 64'(r), 64'(b_val[31:0]));
      rd(3'd3, r); chk("R8 din hi", 64'(r), 64'(b_val[63:32]));
      // R10 read-only and unused addresses
      wr(3'd2, ~b_val[31:0]);
      rd(3'd2, r); chk("R10 din write ignored", 64'(r), 64'(b_val[31:0]));
      rd(3'd6, r); chk("R10 addr6 zero", 64'(r), 64'd0);
      rd(3'd7, r); chk("R10 addr7 zero", 64'(r), 64'd0);
      chk_pads(m, "R7 after ro write");
    end
    // directed direction mapping in mode 11
    do_reset(2'b11);
    wr(3'd0, 32'hFFFF_FFFF); m_dout[31:0] = '1;
    wr(3'd1, 32'hFFFF_FFFF); m_dout[63:32] = '1;
    for (int g = 0; g < 6; g++) begin
      wr(3'd4, 32'(1) << g); m_gdir = 6'(1) << g;
      chk_pads(2'b11, "R4 group bit");
    end
    #1 chk("R4 group5 pads 48..55", pad_oe, 64'h00FF_0000_0000_0000);
    wr(3'd4, 32'd0); m_gdir = '0;
    for (int s = 0; s < 16; s++) begin
      wr(3'd5, 32'(1) << s); m_pdir = 16'(1) << s;
      chk_pads(2'b11, "R5 pin bit");
    end
    #1 chk("R5 pin15 pad 63", pad_oe, 64'h8000_0000_0000_0000);
    wr(3'd5, 32'h0000_0001); m_pdir = 16'h0001;
    #1 chk("R5 pin0 pad 24", pad_oe, 64'h0000_0000_0100_0000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule